// File: doc/BRIEF.md
# Packed Sign-Steered Lane Accumulator

This execution unit speeds up correlation updates in which one factor is a sign, +1 or -1. A product of that kind is either the integer itself or its negation, so the unit needs no multiplier. Each lane runs one add-or-subtract instead.

Each issue supplies three registers:

- a 64-bit operand vector made of eight signed 8-bit lanes;
- a 64-bit accumulator vector with the same lane layout;
- an 8-bit sign register.

A 3-bit row index picks one bit of the sign register. That single bit steers all eight lanes at once. Each lane of the accumulator then gains or loses the matching operand lane. The result is registered and shows on the output one clock edge after the start strobe, together with a valid flag.

A full 8x8 cross-correlation needs 64 such products. The processor covers it by issuing the unit eight times, once for each row index. It feeds each result back as the next accumulator value.

Top module: `simd_sign_mac`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `acc_out` is all zeros and `acc_vld` is low.
- R2: `acc_vld` is high in exactly the cycle that follows a clock edge at which `start` was high. It is low after every edge at which `start` was low.
- R3: If the selected sign bit `sign_bits[row_sel]` is 1 (meaning +1), every lane of `acc_out` becomes accumulator lane plus operand lane, modulo 256.
- R4: If the selected sign bit is 0 (meaning -1), every lane of `acc_out` becomes accumulator lane minus operand lane, modulo 256.
- R5: Only bit `row_sel` of `sign_bits` affects the result, and that one bit steers all eight lanes. Flipping any other bit of `sign_bits` leaves the result unchanged.
- R6: Each lane wraps within its own 8 bits. No carry or borrow passes into the neighbouring lane.
- R7: At an edge where `start` is low, `acc_out` keeps its previous value whatever the data inputs carry.
- R8: Lane k occupies bits [8k+7:8k] of `opnd_in`, `acc_in` and `acc_out`. Each output lane depends only on the input lanes with the same index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue strobe for one row update |
| row_sel | input | 3 | Index of the sign bit that applies |
| sign_bits | input | 8 | Sign register: bit 1 means +1, bit 0 means -1 |
| opnd_in | input | 64 | Eight signed 8-bit operand lanes |
| acc_in | input | 64 | Eight 8-bit accumulator lanes |
| acc_out | output | 64 | Updated accumulator lanes (registered) |
| acc_vld | output | 1 | High for one cycle when `acc_out` carries a fresh result |

## Verification
The updated lanes and `acc_vld` both appear one rising edge after the edge at which `start` is sampled high. The hold behaviour, and the drop of `acc_vld`, also take effect one edge after a low `start`. The bench therefore changes every input on the falling edge and waits one rising edge. It samples a time step later, so each check reads the register state that edge produced. Expected lanes come from a bench function that applies the sign rule lane by lane on the inputs driven for that issue.

// File: rtl/simd_sign_mac.sv
module simd_sign_mac #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int VEC_W = LANES * LANE_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [SEL_W-1:0] row_sel,
  input  logic [LANES-1:0] sign_bits,
  input  logic [VEC_W-1:0] opnd_in,
  input  logic [VEC_W-1:0] acc_in,
  output logic [VEC_W-1:0] acc_out,
  output logic             acc_vld
);

  logic             add_mode;
  logic [VEC_W-1:0] lane_next;

  assign add_mode = sign_bits[row_sel];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, b_eff;
    assign a_l   = acc_in[g*LANE_W +: LANE_W];
    assign b_l   = opnd_in[g*LANE_W +: LANE_W];
    assign b_eff = add_mode ? b_l : ~b_l;
    assign lane_next[g*LANE_W +: LANE_W] = a_l + b_eff + {{(LANE_W-1){1'b0}}, ~add_mode};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_out <= '0;
      acc_vld <= 1'b0;
    end else begin
      acc_vld <= start;
      if (start) acc_out <= lane_next;
    end
  end

endmodule

// File: rtl/simd_sign_mac_chk.sv
module simd_sign_mac_chk #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int VEC_W = LANES * LANE_W,
  localparam int SEL_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [SEL_W-1:0] row_sel,
  input logic [LANES-1:0] sign_bits,
  input logic [VEC_W-1:0] opnd_in,
  input logic [VEC_W-1:0] acc_in,
  input logic [VEC_W-1:0] acc_out,
  input logic             acc_vld
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (acc_out == '0 && !acc_vld));

  a_r2_valid_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> acc_vld);

  a_r2_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !acc_vld);

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(acc_out));

  for (genvar k = 0; k < LANES; k++) begin : g_chk
    a_r3_add_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (start && sign_bits[row_sel]) |=>
        (LANE_W'(acc_out[k*LANE_W +: LANE_W] - $past(opnd_in[k*LANE_W +: LANE_W]))
          == $past(acc_in[k*LANE_W +: LANE_W])));

    a_r4_sub_lane: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !sign_bits[row_sel]) |=>
        (LANE_W'(acc_out[k*LANE_W +: LANE_W] + $past(opnd_in[k*LANE_W +: LANE_W]))
          == $past(acc_in[k*LANE_W +: LANE_W])));
  end

endmodule

bind simd_sign_mac simd_sign_mac_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_sel(row_sel),
  .sign_bits(sign_bits), .opnd_in(opnd_in), .acc_in(acc_in),
  .acc_out(acc_out), .acc_vld(acc_vld)
);

// File: tb/tb_simd_sign_mac.sv
module tb_simd_sign_mac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  row_sel;
  logic [7:0]  sign_bits;
  logic [63:0] opnd_in, acc_in, acc_out;
  logic        acc_vld;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  simd_sign_mac dut (
    .clk(clk), .rst_n(rst_n), .start(start), .row_sel(row_sel),
    .sign_bits(sign_bits), .opnd_in(opnd_in), .acc_in(acc_in),
    .acc_out(acc_out), .acc_vld(acc_vld)
  );

  function automatic logic [63:0] model(input logic [63:0] d, input logic [63:0] c,
                                        input logic [7:0] s, input logic [2:0] r);
    logic [63:0] res;
    for (int k = 0; k < 8; k++) begin
      logic [7:0] a, b;
      a = d[k*8 +: 8];
      b = c[k*8 +: 8];
      res[k*8 +: 8] = s[r] ? 8'(a + b) : 8'(a - b);
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [63:0] d, input logic [63:0] c,
                       input logic [7:0] s, input logic [2:0] r);
    @(negedge clk);
    acc_in = d; opnd_in = c; sign_bits = s; row_sel = r; start = 1'b1;
    @(posedge clk); #1;
    check("R2", {63'd0, acc_vld}, 64'd1);
    check(req, acc_out, model(d, c, s, r));
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle_check();
    logic [63:0] prev;
    prev = acc_out;
    @(negedge clk);
    acc_in = {$urandom, $urandom}; opnd_in = {$urandom, $urandom};
    sign_bits = 8'($urandom); row_sel = 3'($urandom); start = 1'b0;
    @(posedge clk); #1;
    check("R7", acc_out, prev);
    check("R2", {63'd0, acc_vld}, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17_C3E1));
    rst_n = 1'b0; start = 1'b0; row_sel = '0; sign_bits = '0;
    opnd_in = '0; acc_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", acc_out, 64'd0);
    check("R1", {63'd0, acc_vld}, 64'd0);
    rst_n = 1'b1;

    issue("R3", 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 8'hFF, 3'd0);
    issue("R4", 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010, 8'h00, 3'd7);
    issue("R6", 64'h00FF_7F80_0001_FF00, 64'h0001_0101_0002_0101, 8'h08, 3'd3);
    issue("R6", 64'hFF00_0080_7F00_00FF, 64'h0101_0101_FF01_0001, 8'hF7, 3'd3);
    issue("R5", 64'h1122_3344_5566_7788, 64'h0F0F_0F0F_0F0F_0F0F, 8'b0000_0100, 3'd2);
    issue("R5", 64'h1122_3344_5566_7788, 64'h0F0F_0F0F_0F0F_0F0F, 8'b1111_1011, 3'd2);
    issue("R8", 64'h0000_0000_0000_0000, 64'h0000_0000_7F00_0000, 8'h80, 3'd7);
    idle_check();
    idle_check();

    for (int i = 0; i < 150; i++) begin
      logic [63:0] d, c;
      d = {$urandom, $urandom};
      c = {$urandom, $urandom};
      if (i % 20 == 0) c = 64'h8080_8080_8080_8080;
      issue("R3/R4 random", d, c, 8'($urandom), 3'($urandom));
      if (i % 7 == 0) idle_check();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule